// File: doc/BRIEF.md
# Two-Wire Controller Interrupt Aggregator

This block gathers the interrupt events of a two-wire serial bus controller into one place and merges them onto a single interrupt line. Twelve events are tracked. Each event has a sticky raw flag and an enable bit. Most events arrive as one-cycle pulses from the bus engine and the FIFO logic. Three events are produced inside the block:

- an access error, raised when the CPU touches the data port while the FIFO cannot serve it;
- a general call, raised when the received address byte is zero;
- addressed-as-slave, raised when any of four own-address comparators reports a match. The matched comparator is also latched.

Software clears raw flags by writing ones. It sets and clears enable bits through separate write-one strobes that share one write data word. The combined interrupt is registered and follows the enabled raw flags one cycle later. The draining events for partial transfers, raised when the transfer length is not a multiple of the FIFO threshold, arrive as plain pulses like the other bus events.

Top module: `sbus_irq_top`

## Requirements
- R1: After reset `rawStatus`, `enMask` and `matchedAddr` are all zero and `irqOut` is low.
- R2: The raw and enable bit positions are fixed as follows. The event at each bit is set by the input named in brackets.

  | Bit | Event | Set by |
  |-----|-------|--------|
  | 0 | arbitration lost | `evtPulse` |
  | 1 | no-acknowledge | `evtPulse` |
  | 2 | addressed as slave | internal |
  | 3 | registers ready | `evtPulse` |
  | 4 | receive ready | `evtPulse` |
  | 5 | transmit ready | `evtPulse` |
  | 6 | general call | internal |
  | 7 | start condition | `evtPulse` |
  | 8 | bus free (stop condition seen) | `evtPulse` |
  | 9 | access error | internal |
  | 10 | receive draining | `evtPulse` |
  | 11 | transmit draining | `evtPulse` |

- R3: A high `evtPulse` bit at an edge sets the matching raw flag for bits 0, 1, 3, 4, 5, 7, 8, 10 and 11. The `evtPulse` bits 2, 6 and 9 have no effect.
- R4: When `rawClrWe` is high, every raw flag whose `wrData` bit is 1 is cleared. If a flag is set and cleared at the same edge, it ends up set.
- R5: `enSetWe` sets, and `enClrWe` clears, every enable bit whose `wrData` bit is 1. When both strobes hit the same bit, the bit ends up set.
- R6: `irqOut` equals the OR over all bits of (`rawStatus` AND `enMask`) as they stood one cycle earlier.
- R7: Bit 9 (access error) is set when `cpuRd` is high while `rxEmpty` is high, or when `cpuWr` is high while `txFull` is high.
- R8: Bit 6 (general call) is set when `addrValid` is high and `addrByte` is 0x00.
- R9: When `addrValid` is high and `ownMatch` is nonzero, bit 2 is set and `matchedAddr` loads a one-hot code of the lowest-index matching own address. In every other cycle `matchedAddr` holds its value.
- R10: Raw flags and enable bits hold their value until a clear or set acts on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtPulse | input | 12 | Event pulses from the bus engine, one per bit position |
| rxEmpty | input | 1 | Receive FIFO is empty |
| txFull | input | 1 | Transmit FIFO is full |
| cpuRd | input | 1 | CPU read strobe on the data port |
| cpuWr | input | 1 | CPU write strobe on the data port |
| addrValid | input | 1 | Received address byte is valid this cycle |
| addrByte | input | 8 | Received address byte |
| ownMatch | input | 4 | Match flags of the four own-address comparators |
| wrData | input | 12 | Write data for clear and enable strobes |
| rawClrWe | input | 1 | Write-one-to-clear strobe for raw flags |
| enSetWe | input | 1 | Write-one-to-set strobe for enable bits |
| enClrWe | input | 1 | Write-one-to-clear strobe for enable bits |
| rawStatus | output | 12 | Raw event flags |
| enMask | output | 12 | Enable bits |
| matchedAddr | output | 4 | One-hot code of the last matched own address |
| irqOut | output | 1 | Combined registered interrupt |

## Verification
Random cycles mix event pulses, clear and enable writes, FIFO misuse and received addresses. These cycles show whether each flag keeps its own bit and stays sticky. Directed cycles then cover the collisions:

- a set and a clear on the same bit, which separates set-priority from clear-priority;
- enable set and clear on the same bit;
- pulses on the three internally generated bit positions, which reveal any leak from `evtPulse`;
- several own addresses matching at once, which tells lowest-index priority from any other pick;
- a zero address byte together with a match, which shows that general call and addressed-as-slave are detected independently.

Each expected value comes from a bench model of the requirements.

// File: rtl/sbus_irq_pkg.sv
package sbus_irq_pkg;
  localparam int EVT_COUNT  = 12;
  localparam int OWN_COUNT  = 4;
  localparam int ADDR_WIDTH = 8;

  // event bit positions
  localparam int EV_ARB_LOST   = 0;
  localparam int EV_NO_ACK     = 1;
  localparam int EV_ADDR_SLAVE = 2;
  localparam int EV_REGS_READY = 3;
  localparam int EV_RX_READY   = 4;
  localparam int EV_TX_READY   = 5;
  localparam int EV_GEN_CALL   = 6;
  localparam int EV_START      = 7;
  localparam int EV_BUS_FREE   = 8;
  localparam int EV_ACC_ERR    = 9;
  localparam int EV_RX_DRAIN   = 10;
  localparam int EV_TX_DRAIN   = 11;

  // positions driven from inside the block
  localparam logic [EVT_COUNT-1:0] INT_MASK =
    (EVT_COUNT'(1) << EV_ADDR_SLAVE) |
    (EVT_COUNT'(1) << EV_GEN_CALL)   |
    (EVT_COUNT'(1) << EV_ACC_ERR);
  localparam logic [EVT_COUNT-1:0] EXT_MASK = ~INT_MASK;

  typedef struct packed {
    logic [EVT_COUNT-1:0] rawSet;
    logic [EVT_COUNT-1:0] rawClr;
    logic [EVT_COUNT-1:0] enSet;
    logic [EVT_COUNT-1:0] enClr;
    logic                 matchLoad;
    logic [OWN_COUNT-1:0] matchSel;
  } ctrlStb_t;
endpackage

// File: rtl/sbus_irq_ctrl.sv
module sbus_irq_ctrl
  import sbus_irq_pkg::*;
(
  input  logic [EVT_COUNT-1:0]  evtPulse,
  input  logic                  rxEmpty,
  input  logic                  txFull,
  input  logic                  cpuRd,
  input  logic                  cpuWr,
  input  logic                  addrValid,
  input  logic [ADDR_WIDTH-1:0] addrByte,
  input  logic [OWN_COUNT-1:0]  ownMatch,
  input  logic [EVT_COUNT-1:0]  wrData,
  input  logic                  rawClrWe,
  input  logic                  enSetWe,
  input  logic                  enClrWe,
  output ctrlStb_t              stb
);
  logic accErr;
  logic genCall;
  logic anyMatch;
  logic [OWN_COUNT-1:0] lowSel;

  assign accErr   = (cpuRd & rxEmpty) | (cpuWr & txFull);
  assign genCall  = addrValid & (addrByte == '0);
  assign anyMatch = addrValid & (|ownMatch);

  // lowest-index match wins: scan downward so the lowest overwrites
  always_comb begin
    lowSel = '0;
    for (int i = OWN_COUNT - 1; i >= 0; i--) begin
      if (ownMatch[i]) begin
        lowSel    = '0;
        lowSel[i] = 1'b1;
      end
    end
  end

  always_comb begin
    stb                     = '0;
    stb.rawSet              = evtPulse & EXT_MASK;
    stb.rawSet[EV_ACC_ERR]    = accErr;
    stb.rawSet[EV_GEN_CALL]   = genCall;
    stb.rawSet[EV_ADDR_SLAVE] = anyMatch;
    stb.rawClr              = rawClrWe ? wrData : '0;
    stb.enSet               = enSetWe ? wrData : '0;
    stb.enClr               = enClrWe ? wrData : '0;
    stb.matchLoad           = anyMatch;
    stb.matchSel            = lowSel;
  end
endmodule

// File: rtl/sbus_irq_cell.sv
module sbus_irq_cell (
  input  logic clk,
  input  logic rstN,
  input  logic rawSet,
  input  logic rawClr,
  input  logic enSet,
  input  logic enClr,
  output logic rawQ,
  output logic enQ
);
  // set has priority over clear for both flops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ <= 1'b0;
      enQ  <= 1'b0;
    end else begin
      rawQ <= rawSet | (rawQ & ~rawClr);
      enQ  <= enSet  | (enQ  & ~enClr);
    end
  end
endmodule

// File: rtl/sbus_irq_dp.sv
module sbus_irq_dp
  import sbus_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStb_t             stb,
  output logic [EVT_COUNT-1:0] rawVec,
  output logic [EVT_COUNT-1:0] enVec,
  output logic [OWN_COUNT-1:0] matchVec,
  output logic                 irqQ
);
  for (genvar b = 0; b < EVT_COUNT; b++) begin : g_cell
    sbus_irq_cell cell_i (
      .clk    (clk),
      .rstN   (rstN),
      .rawSet (stb.rawSet[b]),
      .rawClr (stb.rawClr[b]),
      .enSet  (stb.enSet[b]),
      .enClr  (stb.enClr[b]),
      .rawQ   (rawVec[b]),
      .enQ    (enVec[b])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchVec <= '0;
      irqQ     <= 1'b0;
    end else begin
      if (stb.matchLoad) matchVec <= stb.matchSel;
      irqQ <= |(rawVec & enVec);
    end
  end
endmodule

// File: rtl/sbus_irq_top.sv
module sbus_irq_top
  import sbus_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [EVT_COUNT-1:0]  evtPulse,
  input  logic                  rxEmpty,
  input  logic                  txFull,
  input  logic                  cpuRd,
  input  logic                  cpuWr,
  input  logic                  addrValid,
  input  logic [ADDR_WIDTH-1:0] addrByte,
  input  logic [OWN_COUNT-1:0]  ownMatch,
  input  logic [EVT_COUNT-1:0]  wrData,
  input  logic                  rawClrWe,
  input  logic                  enSetWe,
  input  logic                  enClrWe,
  output logic [EVT_COUNT-1:0]  rawStatus,
  output logic [EVT_COUNT-1:0]  enMask,
  output logic [OWN_COUNT-1:0]  matchedAddr,
  output logic                  irqOut
);
  ctrlStb_t stb;

  sbus_irq_ctrl ctrl_i (
    .evtPulse  (evtPulse),
    .rxEmpty   (rxEmpty),
    .txFull    (txFull),
    .cpuRd     (cpuRd),
    .cpuWr     (cpuWr),
    .addrValid (addrValid),
    .addrByte  (addrByte),
    .ownMatch  (ownMatch),
    .wrData    (wrData),
    .rawClrWe  (rawClrWe),
    .enSetWe   (enSetWe),
    .enClrWe   (enClrWe),
    .stb       (stb)
  );

  sbus_irq_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rawVec   (rawStatus),
    .enVec    (enMask),
    .matchVec (matchedAddr),
    .irqQ     (irqOut)
  );
endmodule

// File: rtl/sbus_irq_chk.sv
module sbus_irq_chk
  import sbus_irq_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [EVT_COUNT-1:0]  evtPulse,
  input logic                  rxEmpty,
  input logic                  txFull,
  input logic                  cpuRd,
  input logic                  cpuWr,
  input logic                  addrValid,
  input logic [ADDR_WIDTH-1:0] addrByte,
  input logic [OWN_COUNT-1:0]  ownMatch,
  input logic [EVT_COUNT-1:0]  wrData,
  input logic                  rawClrWe,
  input logic                  enSetWe,
  input logic                  enClrWe,
  input logic [EVT_COUNT-1:0]  rawStatus,
  input logic [EVT_COUNT-1:0]  enMask,
  input logic [OWN_COUNT-1:0]  matchedAddr,
  input logic                  irqOut
);
  a_r3_ext_set: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawStatus & $past(evtPulse & EXT_MASK)) == $past(evtPulse & EXT_MASK)));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    rawClrWe |=> ((rawStatus & $past(wrData & EXT_MASK & ~evtPulse)) == '0));

  a_r5_en_set: assert property (@(posedge clk) disable iff (!rstN)
    enSetWe |=> ((enMask & $past(wrData)) == $past(wrData)));

  a_r6_irq: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(rawStatus & enMask))));

  a_r7_acc_err: assert property (@(posedge clk) disable iff (!rstN)
    ((cpuRd && rxEmpty) || (cpuWr && txFull)) |=> rawStatus[EV_ACC_ERR]);

  a_r8_gen_call: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && addrByte == '0) |=> rawStatus[EV_GEN_CALL]);

  a_r9_match_load: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && |ownMatch) |=> ($onehot(matchedAddr) && rawStatus[EV_ADDR_SLAVE]));

  a_r9_match_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(addrValid && |ownMatch) |=> $stable(matchedAddr));

  a_r10_en_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(enSetWe || enClrWe) |=> $stable(enMask));
endmodule

bind sbus_irq_top sbus_irq_chk chk_i (.*);

// File: tb/sbus_irq_top_tb_top.sv
`timescale 1ns/1ps
module sbus_irq_top_tb_top;
  localparam int NE = 12;
  localparam logic [NE-1:0] EXTM = 12'hDBB; // bits 2,6,9 internal (R2)

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NE-1:0] evtPulse = '0;
  logic rxEmpty = 0, txFull = 0, cpuRd = 0, cpuWr = 0, addrValid = 0;
  logic [7:0] addrByte = '0;
  logic [3:0] ownMatch = '0;
  logic [NE-1:0] wrData = '0;
  logic rawClrWe = 0, enSetWe = 0, enClrWe = 0;
  logic [NE-1:0] rawStatus, enMask;
  logic [3:0] matchedAddr;
  logic irqOut;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [NE-1:0] expRaw = '0, expEn = '0;
  logic [3:0] expMatch = '0;
  logic expIrq = 0;

  always #2.5 clk = ~clk;

  sbus_irq_top dut_i (.*);

  function automatic logic [NE-1:0] nextRaw(logic [NE-1:0] r);
    logic [NE-1:0] s;
    s = evtPulse & EXTM;
    if ((cpuRd && rxEmpty) || (cpuWr && txFull)) s[9] = 1'b1;
    if (addrValid && addrByte == 8'h00) s[6] = 1'b1;
    if (addrValid && ownMatch != 0) s[2] = 1'b1;
    return (r & ~(rawClrWe ? wrData : '0)) | s;
  endfunction

  function automatic logic [NE-1:0] nextEn(logic [NE-1:0] e);
    return (e & ~(enClrWe ? wrData : '0)) | (enSetWe ? wrData : '0);
  endfunction

  function automatic logic [3:0] nextMatch(logic [3:0] m);
    if (!(addrValid && ownMatch != 0)) return m;
    for (int i = 0; i < 4; i++) if (ownMatch[i]) return 4'(1 << i);
    return m;
  endfunction

  task automatic check(string tag, logic [NE-1:0] act, logic [NE-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearIns();
    evtPulse = '0; rxEmpty = 0; txFull = 0; cpuRd = 0; cpuWr = 0;
    addrValid = 0; addrByte = 8'h55; ownMatch = '0; wrData = '0;
    rawClrWe = 0; enSetWe = 0; enClrWe = 0;
  endtask

  // inputs already driven at a negedge; advance one edge and check
  task automatic step(string tag);
    logic [NE-1:0] r, e;
    logic [3:0] m;
    logic q;
    q = |(expRaw & expEn);
    r = nextRaw(expRaw);
    e = nextEn(expEn);
    m = nextMatch(expMatch);
    @(posedge clk);
    @(negedge clk);
    expRaw = r; expEn = e; expMatch = m; expIrq = q;
    check({tag, " raw"}, rawStatus, expRaw);
    check({tag, " en"}, enMask, expEn);
    check({tag, " match"}, NE'(matchedAddr), NE'(expMatch));
    check({tag, " irq R6"}, NE'(irqOut), NE'(expIrq));
    clearIns();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    clearIns();
    repeat (3) @(negedge clk);
    check("R1 raw", rawStatus, '0);
    check("R1 en", enMask, '0);
    check("R1 match", NE'(matchedAddr), '0);
    check("R1 irq", NE'(irqOut), '0);
    rstN = 1;
    @(negedge clk);

    // R3: internal positions ignore evtPulse
    evtPulse = 12'hFFF; step("R3 pulse all");
    wrData = 12'hFFF; rawClrWe = 1; step("R4 clear all");
    // R4: set and clear on same bit -> set
    evtPulse = 12'h010; wrData = 12'h011; rawClrWe = 1; step("R4 set wins");
    // R5: enable set and clear together
    wrData = 12'h0F0; enSetWe = 1; step("R5 en set");
    wrData = 12'h030; enClrWe = 1; enSetWe = 1; step("R5 both");
    wrData = 12'h0C0; enClrWe = 1; step("R5 en clear");
    step("R10 hold");
    // R6: irq via enabled flag
    wrData = 12'h010; enSetWe = 1; step("R6 enable");
    step("R6 irq high");
    wrData = 12'hFFF; rawClrWe = 1; step("R6 clear");
    step("R6 irq low");
    // R7
    cpuRd = 1; rxEmpty = 1; step("R7 read empty");
    cpuWr = 1; txFull = 0; rxEmpty = 1; step("R7 write ok");
    wrData = 12'h200; rawClrWe = 1; step("R7 clear");
    cpuWr = 1; txFull = 1; step("R7 write full");
    // R8 + R9
    addrValid = 1; addrByte = 8'h00; ownMatch = 4'b0000; step("R8 gen call");
    addrValid = 1; addrByte = 8'h00; ownMatch = 4'b1100; step("R9 R8 both");
    addrValid = 1; addrByte = 8'h3A; ownMatch = 4'b1010; step("R9 low pick");
    addrValid = 1; addrByte = 8'h3A; ownMatch = 4'b0000; step("R9 no match hold");
    addrValid = 0; ownMatch = 4'b0001; step("R9 not valid hold");
    addrValid = 1; addrByte = 8'h01; ownMatch = 4'b1000; step("R9 single");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      evtPulse = (($urandom % 4) == 0) ? NE'($urandom) : '0;
      rxEmpty = $urandom; txFull = $urandom;
      cpuRd = (($urandom % 5) == 0); cpuWr = (($urandom % 5) == 0);
      addrValid = (($urandom % 4) == 0);
      addrByte = (($urandom % 3) == 0) ? 8'h00 : 8'($urandom);
      ownMatch = 4'($urandom);
      wrData = NE'($urandom);
      rawClrWe = (($urandom % 3) == 0);
      enSetWe = (($urandom % 4) == 0);
      enClrWe = (($urandom % 4) == 0);
      step("R10 random");
    end
    finishRun();
  end
endmodule